// File: doc/BRIEF.md
# Safety Fault Counter with Reset Reaction

This block supervises a system's reset behaviour by counting fault events and reacting once the count reaches a configured threshold. Two sources feed the counter: each new falling edge on the shared active-low system reset line, and an internal fault request that counts once per cycle it is held high. The count is never cleared by a functional reset. Only the power-on reset input clears it, so a run of ordinary resets can build up towards the threshold.

When an increment brings the count to or past the threshold, the block drives a reaction for a fixed 16-cycle pulse. The 2-bit reaction code in the configuration register sets which outputs take part. The reset output can act alone, or together with the fail-safe output, or together with both the fail-safe output and the power-good output. Pulling power-good low forces a power-on reset downstream. Falling edges on the reset line during the block's own pulse are not counted.

The configuration register can be written from a simple write port. A write takes effect only when a separate shadow register already holds the bitwise complement of the written value. A write that fails this test leaves the configuration unchanged and sets a sticky error flag.

Top module: `flt_supervisor`

## Requirements
- R1: While `por_n` is low and right after it rises, `fault_count` is 0, `rst_out_n`, `fs_out_n` and `pgood` are 1, and `cfg_err` is 0. The configuration defaults to limit code 0 and reaction code 3, and the shadow register defaults to the complement of that configuration.
- R2: A falling edge of `rst_line_n` seen while `rst_out_n` is high adds one to `fault_count`. The count updates at the clock edge that first samples the line low. Holding the line low adds nothing more.
- R3: Each clock edge that samples `int_fault` high adds one. When a new line falling edge and `int_fault` occur at the same edge, the count rises by two.
- R4: The count saturates at the maximum value 2*L+4, where L is the limit code in configuration bits [1:0]. It never wraps.
- R5: The reaction fires at the edge where an increment moves the count from below the threshold L+3 to at or above it, provided the reaction code is nonzero. With the default configuration, this happens at the third fault. From that edge, `rst_out_n` is low for exactly 16 cycles.
- R6: The reaction code sits in configuration bits [3:2]. Code 0 gives no reaction. Code 1 drives only `rst_out_n` low. Code 2 also drives `fs_out_n` low. Code 3 also drives `pgood` low for the same pulse.
- R7: A write with `wr_en`=1 and `wr_sel`=1 loads the shadow register. A write with `wr_sel`=0 loads the configuration only if `wr_data` equals the bitwise complement of the shadow register. The new configuration applies from the next clock edge.
- R8: A configuration write that fails the complement test leaves the configuration unchanged and sets `cfg_err`. `cfg_err` stays set through later valid writes and clears only on `por_n`.
- R9: The count never decreases while `por_n` is high. Line edges that occur while the block's own pulse holds `rst_out_n` low are not counted.
- R10: The reaction fires at most once per threshold crossing. Further faults after the crossing, including those at saturation, start no new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset; clears all state |
| rst_line_n | input | 1 | Shared active-low system reset line, sampled each cycle |
| int_fault | input | 1 | Internal fault request, counts once per cycle high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the configuration register, 1 the complement shadow register |
| wr_data | input | 4 | Write data: [1:0] limit code, [3:2] reaction code |
| rst_out_n | output | 1 | Active-low reset output driven by the reaction |
| fs_out_n | output | 1 | Active-low fail-safe output |
| pgood | output | 1 | Power-good output; low forces a downstream power-on reset |
| cfg_err | output | 1 | Sticky flag for a rejected configuration write |
| fault_count | output | CNT_W | Current fault count |

## Verification
`fault_count` changes at the same rising edge that first samples a new low on the reset line or a high `int_fault`. A reaction started by that increment drives the outputs low immediately after that edge and holds them for 16 edges. A configuration write changes behaviour only for events sampled at later edges. The bench drives inputs at the falling edge and keeps a behavioural reference model that steps at each rising edge. It compares every output with the model at the next falling edge, so each result is checked in the half cycle after the edge that produced it. Directed checks at the same falling edges compare against fixed values worked out from the requirements.

// File: rtl/flt_supervisor.sv
module flt_supervisor #(
  parameter int          CNT_W     = 4,
  parameter int          PULSE_LEN = 16,
  parameter logic [3:0]  CFG_RST   = 4'b1100
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_line_n,
  input  logic             int_fault,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [3:0]       wr_data,
  output logic             rst_out_n,
  output logic             fs_out_n,
  output logic             pgood,
  output logic             cfg_err,
  output logic [CNT_W-1:0] fault_count
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam int SW = CNT_W + 1;

  logic [3:0]       cfg_q, shadow_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    pcnt_q;
  logic             fs_en_q, pg_en_q, line_q, err_q;

  logic             active, ext_fall, fire, cfg_wr_ok, cfg_wr_bad;
  logic [SW-1:0]    thr, cmax, sum, nxt;

  assign active   = (pcnt_q != '0);
  assign ext_fall = line_q & ~rst_line_n & ~active;

  assign thr  = SW'(cfg_q[1:0]) + SW'(3);
  assign cmax = SW'({cfg_q[1:0], 1'b0}) + SW'(4);
  assign sum  = SW'(cnt_q) + SW'(ext_fall) + SW'(int_fault);
  assign nxt  = (sum > cmax) ? cmax : sum;
  assign fire = (cfg_q[3:2] != 2'b00) && (SW'(cnt_q) < thr) && (nxt >= thr);

  assign cfg_wr_ok  = wr_en & ~wr_sel & (wr_data == ~shadow_q);
  assign cfg_wr_bad = wr_en & ~wr_sel & (wr_data != ~shadow_q);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      line_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      line_q <= rst_line_n;
      cnt_q  <= nxt[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pcnt_q  <= '0;
      fs_en_q <= 1'b0;
      pg_en_q <= 1'b0;
    end else if (fire) begin
      pcnt_q  <= PW'(PULSE_LEN);
      fs_en_q <= cfg_q[3];
      pg_en_q <= &cfg_q[3:2];
    end else if (active) begin
      pcnt_q  <= pcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg_q    <= CFG_RST;
      shadow_q <= ~CFG_RST;
      err_q    <= 1'b0;
    end else begin
      if (wr_en && wr_sel) shadow_q <= wr_data;
      if (cfg_wr_ok)       cfg_q    <= wr_data;
      if (cfg_wr_bad)      err_q    <= 1'b1;
    end
  end

  assign rst_out_n   = ~active;
  assign fs_out_n    = ~(active & fs_en_q);
  assign pgood       = ~(active & pg_en_q);
  assign cfg_err     = err_q;
  assign fault_count = cnt_q;
endmodule

module flt_supervisor_chk #(
  parameter int CNT_W     = 4,
  parameter int PULSE_LEN = 16
) (
  input logic             clk,
  input logic             por_n,
  input logic             int_fault,
  input logic             rst_out_n,
  input logic             fs_out_n,
  input logic             pgood,
  input logic             cfg_err,
  input logic [CNT_W-1:0] fault_count
);
  int lowcnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          lowcnt <= 0;
    else if (!rst_out_n) lowcnt <= lowcnt + 1;
    else                 lowcnt <= 0;
  end

  // R9
  cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!por_n)
    fault_count >= $past(fault_count));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!por_n)
    (int'(fault_count) - int'($past(fault_count))) <= 2);

  // R5
  pulse_len_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_out_n) |-> lowcnt == PULSE_LEN);

  // R6
  fs_with_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    !fs_out_n |-> !rst_out_n);

  // R6
  pg_with_fs_chk: assert property (@(posedge clk) disable iff (!por_n)
    !pgood |-> !fs_out_n);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    $past(cfg_err) |-> cfg_err);

  // R9
  own_pulse_ignored_chk: assert property (@(posedge clk) disable iff (!por_n)
    ($past(!rst_out_n) && !$past(int_fault)) |-> fault_count == $past(fault_count));
endmodule

bind flt_supervisor flt_supervisor_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .por_n(por_n), .int_fault(int_fault), .rst_out_n(rst_out_n),
  .fs_out_n(fs_out_n), .pgood(pgood), .cfg_err(cfg_err), .fault_count(fault_count)
);

// File: tb/test_flt_supervisor.sv
module test_flt_supervisor;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic ext_n = 1'b1;
  logic int_fault = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [3:0] wr_data = '0;
  logic rst_out_n, fs_out_n, pgood, cfg_err;
  logic [3:0] fault_count;
  logic line_n;

  assign line_n = ext_n & rst_out_n;

  flt_supervisor i_flt_supervisor (
    .clk(clk), .por_n(por_n), .rst_line_n(line_n), .int_fault(int_fault),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rst_out_n(rst_out_n), .fs_out_n(fs_out_n), .pgood(pgood),
    .cfg_err(cfg_err), .fault_count(fault_count)
  );

  always #2 clk = ~clk;

  int total = 0, fails = 0;
  int m_cnt, m_lim, m_imp, m_shadow, m_err, m_pcnt, m_fs, m_pg, m_lnq;
  bit m_live = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic m_reset();
    m_cnt = 0; m_lim = 0; m_imp = 3; m_shadow = 4'b0011; m_err = 0;
    m_pcnt = 0; m_fs = 0; m_pg = 0; m_lnq = 1;
  endtask

  always @(posedge clk) begin
    if (!por_n) begin
      m_reset();
      m_live = 0;
    end else begin
      int line, fall, nv, thr, mx, fire;
      line = (ext_n && m_pcnt == 0) ? 1 : 0;
      fall = (m_lnq == 1 && line == 0 && m_pcnt == 0) ? 1 : 0;
      thr  = m_lim + 3;
      mx   = 2 * m_lim + 4;
      nv   = m_cnt + fall + (int_fault ? 1 : 0);
      if (nv > mx) nv = mx;
      fire = (m_imp != 0 && m_cnt < thr && nv >= thr) ? 1 : 0;
      if (fire) begin
        m_pcnt = 16; m_fs = (m_imp >= 2); m_pg = (m_imp == 3);
      end else if (m_pcnt > 0) m_pcnt--;
      m_cnt = nv;
      m_lnq = line;
      if (wr_en && wr_sel) m_shadow = wr_data;
      else if (wr_en) begin
        if (wr_data == (~m_shadow & 15)) begin m_lim = wr_data & 3; m_imp = wr_data >> 2; end
        else m_err = 1;
      end
      m_live = 1;
    end
  end

  always @(negedge clk) begin
    if (por_n && m_live) begin
      check(fault_count == m_cnt, "R2 count vs model", fault_count, m_cnt);
      check(rst_out_n == (m_pcnt == 0), "R5 rst_out_n vs model", rst_out_n, m_pcnt == 0);
      check(fs_out_n == !(m_pcnt != 0 && m_fs), "R6 fs_out_n vs model", fs_out_n, !(m_pcnt != 0 && m_fs));
      check(pgood == !(m_pcnt != 0 && m_pg), "R6 pgood vs model", pgood, !(m_pcnt != 0 && m_pg));
      check(cfg_err == m_err, "R8 cfg_err vs model", cfg_err, m_err);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_por();
    por_n = 1'b0; ext_n = 1'b1; int_fault = 1'b0; wr_en = 1'b0;
    tick(3);
    por_n = 1'b1;
    tick(1);
  endtask

  task automatic ext_pulse(input int n);
    ext_n = 1'b0; tick(n); ext_n = 1'b1; tick(1);
  endtask

  task automatic fault(input int n);
    int_fault = 1'b1; tick(n); int_fault = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [3:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; tick(1); wr_en = 1'b0;
  endtask

  initial begin
    #400000;
    fails++; total++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    m_reset();
    tick(2);
    check(fault_count == 0 && rst_out_n && fs_out_n && pgood && !cfg_err, "R1 during por", fault_count, 0);
    por_n = 1'b1; tick(1);
    check(fault_count == 0 && rst_out_n && fs_out_n && pgood && !cfg_err, "R1 after por", fault_count, 0);

    ext_pulse(3);
    check(fault_count == 1, "R2 held low counts once", fault_count, 1);
    ext_pulse(1);
    check(fault_count == 2, "R2 second edge", fault_count, 2);
    check(rst_out_n == 1, "R5 no reaction below threshold", rst_out_n, 1);
    fault(1);
    check(fault_count == 3, "R3 internal fault", fault_count, 3);
    check(!rst_out_n && !fs_out_n && !pgood, "R5 default reaction", {rst_out_n, fs_out_n, pgood}, 0);
    tick(3);
    ext_pulse(2);
    check(fault_count == 3, "R9 own pulse edges ignored", fault_count, 3);
    tick(20);
    check(rst_out_n && fs_out_n && pgood, "R5 released after pulse", {rst_out_n, fs_out_n, pgood}, 7);
    ext_pulse(1);
    check(fault_count == 4, "R2 count after release", fault_count, 4);
    ext_pulse(1);
    fault(3);
    check(fault_count == 4, "R4 saturates at 4", fault_count, 4);
    check(rst_out_n == 1, "R10 no second pulse", rst_out_n, 1);

    do_por();
    check(fault_count == 0, "R1 count cleared by por", fault_count, 0);
    ext_n = 1'b0; int_fault = 1'b1; tick(1); ext_n = 1'b1; int_fault = 1'b0;
    check(fault_count == 2, "R3 two events one edge", fault_count, 2);
    tick(20);

    do_por();
    wr(1'b1, 4'b1010);
    wr(1'b0, 4'b0000);
    check(cfg_err == 1, "R8 mismatch sets error", cfg_err, 1);
    fault(3);
    check(!rst_out_n && !pgood, "R8 config kept after mismatch", {rst_out_n, pgood}, 0);
    tick(20);

    do_por();
    wr(1'b1, 4'b1010);
    wr(1'b0, 4'b0101);
    check(cfg_err == 0, "R7 matched write accepted", cfg_err, 0);
    fault(3);
    check(fault_count == 3 && rst_out_n, "R7 new threshold 4", rst_out_n, 1);
    fault(1);
    check(!rst_out_n && fs_out_n && pgood, "R6 code 1 reset only", {rst_out_n, fs_out_n, pgood}, 3);
    tick(20);
    fault(5);
    check(fault_count == 6, "R4 saturates at 6", fault_count, 6);

    do_por();
    wr(1'b1, 4'b0111);
    wr(1'b0, 4'b1000);
    fault(3);
    check(!rst_out_n && !fs_out_n && pgood, "R6 code 2 reset and failsafe", {rst_out_n, fs_out_n, pgood}, 1);
    tick(20);

    do_por();
    wr(1'b1, 4'b1111);
    wr(1'b0, 4'b0000);
    fault(3);
    check(fault_count == 3 && rst_out_n && fs_out_n && pgood, "R6 code 0 no reaction", rst_out_n, 1);
    wr(1'b0, 4'b0001);
    wr(1'b1, 4'b1110);
    wr(1'b0, 4'b0001);
    check(cfg_err == 1, "R8 error stays after valid write", cfg_err, 1);
    do_por();
    check(cfg_err == 0, "R8 error cleared by por", cfg_err, 0);

    tick(2);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule